// File: doc/BRIEF.md
# Synchronous Burst Read Flash Interface

This block is the memory-side controller for synchronous burst reads on a 32-bit flash-style data bus. A start address is captured on an active edge of the burst clock while chip select and the latch strobe are both low. After that, each active burst clock edge with the advance input low moves an internal 19-bit word counter forward by one. The word the counter points at is offered on the data bus whenever the output controls allow it. The array behind the counter is a small constant word store whose contents are computed from the index.

The block runs on a fast system clock `clk`. The burst clock `bclk` is sampled in that domain, and its active edge (rising or falling, selected by `cfg_fall`) becomes a one-cycle step pulse. Two output controls, `oe_n` and `od_n`, act independently of advance. Their combinations give held data, stepping with the bus released, and suspend/resume. Raising chip select or pulling reset low aborts the burst. A fresh address latch is then needed before data flows again. The ready output either follows the burst exactly or leads it by one burst cycle. The bus is modelled as `data_o` plus a drive enable `data_oe`. While the bus is released, `data_o` reads zero.

The controller has four states. `ST_IDLE` means no valid burst. `ST_STREAM` means the last active edge latched or stepped. `ST_HOLD` means advance was high with the outputs enabled. `ST_SUSPEND` means advance and `oe_n` were both high. The transitions are:
- Latch: any state to `ST_STREAM` on an active edge with the strobe low.
- Step: a valid state to `ST_STREAM` with advance low.
- Pause: a valid state to `ST_HOLD` or `ST_SUSPEND`, depending on `oe_n`, with advance high.
- Abort: any state to `ST_IDLE` on any `clk` cycle with `ce_n` or `cfg_async` high, or asynchronously on reset.

Top module: `sbr_flash_if`

## Requirements
- R1: While `rst_n` is low, `data_oe`=0, `data_o`=0 and `rdy`=0. Reset leaves no valid burst.
- R2: On an active `bclk` edge with `ce_n`=0, `lat_n`=0 and `cfg_async`=0, the counter loads `addr`. The latch has priority over stepping.
- R3: On an active edge in a valid burst with `ce_n`=0, `lat_n`=1 and `adv_n`=0, the counter increments by one. It wraps from 19'h7FFFF to 0.
- R4: Stepping in R3 also happens while `oe_n`=1 or `od_n`=0. During that time the bus is released (`data_oe`=0).
- R5: An active edge with `adv_n`=1 leaves the counter unchanged. With `oe_n`=0 and `od_n`=1 the bus keeps the same word.
- R6: With `adv_n`=1 and `oe_n`=1 the burst is suspended: the bus is released and the counter is held. Taking `oe_n` low resumes with the held word.
- R7: `data_oe`=1 exactly when a burst is valid, `rst_n`=1, `ce_n`=0, `oe_n`=0, `od_n`=1 and `cfg_async`=0. Then `data_o` equals the word at the counter; otherwise `data_o`=0.
- R8: `ce_n`=1 on any `clk` cycle aborts the burst. After `ce_n` returns low, no data is driven and normal-mode `rdy` stays 0 until a new latch.
- R9: The active edge is rising when `cfg_fall`=0 and falling when `cfg_fall`=1. An inactive edge neither latches nor steps.
- R10: `rdy` = `rst_n` & !`ce_n` & !`cfg_async` & (burst valid | (`cfg_rdy_early` & !`lat_n`)). Early mode therefore raises ready during the latch cycle, before the latching edge.
- R11: With `cfg_async`=1 the latch is ignored, any burst is ended, the bus is released and `rdy`=0.
- R12: The word at counter value a is ((a mod DEPTH)+1) × 32'h9E3779B9, truncated to 32 bits, with DEPTH=16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset and abort |
| bclk | input | 1 | Burst clock, synchronous to clk |
| ce_n | input | 1 | Active-low chip select |
| lat_n | input | 1 | Active-low address latch strobe |
| adv_n | input | 1 | Active-low burst advance |
| oe_n | input | 1 | Active-low output enable |
| od_n | input | 1 | Active-low output disable (low releases the bus) |
| addr | input | 19 | Burst start address |
| cfg_fall | input | 1 | 1 selects the falling burst clock edge as active |
| cfg_rdy_early | input | 1 | 1 makes ready lead by one burst cycle |
| cfg_async | input | 1 | 1 disables synchronous burst mode |
| data_o | output | 32 | Read data, zero when not driven |
| data_oe | output | 1 | Data bus drive enable |
| rdy | output | 1 | Valid-data-ready |

## Verification
The assertions assume the following about the inputs:
- `bclk` is already synchronous to `clk` and stays at each level for at least one `clk` cycle, so every burst clock transition yields exactly one step pulse.
- `addr`, `lat_n` and `adv_n` are stable around the `clk` edge where that pulse is taken.
- The configuration inputs change only while no step pulse is pending.

The stimulus drives every input at the falling `clk` edge, holds each `bclk` level for two `clk` cycles, and changes `cfg_fall` only while `bclk` is low.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STREAM,
        ST_HOLD,
        ST_SUSPEND
    } burst_st_e;

    localparam logic [31:0] WORD_MULT = 32'h9E37_79B9;

    // Constant array contents: (index + 1) times a fixed odd multiplier.
    function automatic logic [31:0] word_pattern(input int unsigned idx);
        logic [31:0] p;
        p = (idx + 32'd1) * WORD_MULT;
        return p;
    endfunction

endpackage

// File: rtl/sbr_edge_det.sv
module sbr_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk,
    input  logic fall_sel,
    output logic act_o
);
    logic bclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bclk_q <= 1'b0;
        else        bclk_q <= bclk;
    end

    always_comb begin
        if (fall_sel) act_o = bclk_q & ~bclk;
        else          act_o = ~bclk_q & bclk;
    end

    // R9: a step pulse never lasts two cycles with a steady burst clock
    p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (act_o && $stable(fall_sel)) |=> !act_o || (bclk != $past(bclk)));

endmodule

// File: rtl/sbr_word_rom.sv
module sbr_word_rom #(
    parameter int AW    = 19,
    parameter int DW    = 32,
    parameter int DEPTH = 16
) (
    input  logic [AW-1:0] addr,
    output logic [DW-1:0] word_o
);
    localparam int IW = $clog2(DEPTH);

    logic [DW-1:0] rom [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        assign rom[g] = DW'(sbr_pkg::word_pattern(g));
    end

    assign word_o = rom[addr[IW-1:0]];

    logic unused_ok;
    assign unused_ok = &{1'b0, addr[AW-1:IW]};

endmodule

// File: rtl/sbr_burst_fsm.sv
module sbr_burst_fsm #(
    parameter int AW = 19
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          act,
    input  logic          ce_n,
    input  logic          lat_n,
    input  logic          adv_n,
    input  logic          oe_n,
    input  logic          async_mode,
    input  logic [AW-1:0] addr,
    output logic [AW-1:0] cnt_o,
    output logic          valid_o
);
    import sbr_pkg::*;

    burst_st_e     st_q, st_d;
    logic [AW-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Next state
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (ce_n || async_mode) begin
            st_d = ST_IDLE;                         // abort
        end else if (act) begin
            unique case (st_q)
                ST_IDLE: begin
                    if (!lat_n) begin
                        st_d  = ST_STREAM;          // latch
                        cnt_d = addr;
                    end
                end
                ST_STREAM, ST_HOLD, ST_SUSPEND: begin
                    if (!lat_n) begin
                        st_d  = ST_STREAM;          // re-latch
                        cnt_d = addr;
                    end else if (!adv_n) begin
                        st_d  = ST_STREAM;          // step
                        cnt_d = cnt_q + AW'(1);
                    end else begin
                        st_d  = oe_n ? ST_SUSPEND : ST_HOLD;  // pause
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        valid_o = (st_q != ST_IDLE);
        cnt_o   = cnt_q;
    end

    p_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (act && !ce_n && !lat_n && !async_mode) |=> (cnt_q == $past(addr)));

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (act && !ce_n && lat_n && !adv_n && !async_mode && st_q != ST_IDLE)
        |=> (cnt_q == $past(cnt_q) + AW'(1)));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (act && !ce_n && lat_n && adv_n && !async_mode) |=> $stable(cnt_q));

    p_suspend_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (act && !ce_n && lat_n && adv_n && oe_n && !async_mode && st_q != ST_IDLE)
        |=> (st_q == ST_SUSPEND));

    p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || async_mode) |=> (st_q == ST_IDLE));

    p_no_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!act && !ce_n && !async_mode) |=> ($stable(cnt_q) && $stable(st_q)));

endmodule

// File: rtl/sbr_flash_if.sv
module sbr_flash_if #(
    parameter int AW    = 19,
    parameter int DW    = 32,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bclk,
    input  logic          ce_n,
    input  logic          lat_n,
    input  logic          adv_n,
    input  logic          oe_n,
    input  logic          od_n,
    input  logic [AW-1:0] addr,
    input  logic          cfg_fall,
    input  logic          cfg_rdy_early,
    input  logic          cfg_async,
    output logic [DW-1:0] data_o,
    output logic          data_oe,
    output logic          rdy
);
    logic          act;
    logic          burst_valid;
    logic [AW-1:0] cnt;
    logic [DW-1:0] word;

    sbr_edge_det u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .bclk     (bclk),
        .fall_sel (cfg_fall),
        .act_o    (act)
    );

    sbr_burst_fsm #(.AW(AW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .act        (act),
        .ce_n       (ce_n),
        .lat_n      (lat_n),
        .adv_n      (adv_n),
        .oe_n       (oe_n),
        .async_mode (cfg_async),
        .addr       (addr),
        .cnt_o      (cnt),
        .valid_o    (burst_valid)
    );

    sbr_word_rom #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_rom (
        .addr   (cnt),
        .word_o (word)
    );

    always_comb begin
        data_oe = burst_valid && rst_n && !ce_n && !oe_n && od_n && !cfg_async;
        data_o  = data_oe ? word : '0;
        rdy     = rst_n && !ce_n && !cfg_async &&
                  (burst_valid || (cfg_rdy_early && !lat_n));
    end

    p_drive_needs_burst_r7: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> burst_valid);

    p_quiet_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !data_oe |-> (data_o == '0));

    p_rdy_normal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && !cfg_rdy_early) |-> burst_valid);

    p_async_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_async |-> (!rdy && !data_oe));

endmodule

// File: tb/sbr_flash_if_tb.sv
module sbr_flash_if_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk = 1'b0;
    logic        ce_n = 1'b1, lat_n = 1'b1, adv_n = 1'b1, oe_n = 1'b1, od_n = 1'b1;
    logic [18:0] addr = '0;
    logic        cfg_fall = 1'b0, cfg_rdy_early = 1'b0, cfg_async = 1'b0;
    logic [31:0] data_o;
    logic        data_oe, rdy;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    always #10 clk = ~clk;   // 50 MHz

    sbr_flash_if dut_i (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .ce_n(ce_n), .lat_n(lat_n),
        .adv_n(adv_n), .oe_n(oe_n), .od_n(od_n), .addr(addr),
        .cfg_fall(cfg_fall), .cfg_rdy_early(cfg_rdy_early), .cfg_async(cfg_async),
        .data_o(data_o), .data_oe(data_oe), .rdy(rdy)
    );

    // Reference model
    bit m_valid = 1'b0;
    int m_addr = 0;
    bit m_bprev = 1'b0;

    function automatic logic [31:0] ref_word(int a);
        logic [31:0] w;
        w = 32'((a % 16) + 1) * 32'h9E3779B9;
        return w;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_valid = 1'b0;
            m_addr  = 0;
            m_bprev = 1'b0;
        end else begin
            bit e;
            e = cfg_fall ? (m_bprev && !bclk) : (!m_bprev && bclk);
            m_bprev = bclk;
            if (ce_n || cfg_async) m_valid = 1'b0;
            else if (e) begin
                if (!lat_n) begin
                    m_addr  = int'(addr);
                    m_valid = 1'b1;
                end else if (m_valid && !adv_n) begin
                    m_addr = (m_addr + 1) & 32'h7FFFF;
                end
            end
        end
    end

    task automatic chk(bit ok, string req, logic [31:0] act_v, logic [31:0] exp_v);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act_v, exp_v, $time);
        end
    endtask

    task automatic compare();
        bit          e_oe, e_rdy;
        logic [31:0] e_data;
        e_oe   = m_valid && rst_n && !ce_n && !oe_n && od_n && !cfg_async;
        e_rdy  = rst_n && !ce_n && !cfg_async && (m_valid || (cfg_rdy_early && !lat_n));
        e_data = e_oe ? ref_word(m_addr) : 32'h0;
        chk(data_oe == e_oe && rdy == e_rdy && data_o == e_data, cur_req,
            {data_oe, rdy, data_o[29:0]}, {e_oe, e_rdy, e_data[29:0]});
    endtask

    task automatic tick();
        @(negedge clk);
        compare();
    endtask

    task automatic half();
        bclk = ~bclk;
        tick();
        tick();
    endtask

    task automatic bcyc(int n);
        for (int i = 0; i < n; i++) begin
            half();
            half();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R1 watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // R1 reset
        cur_req = "R1";
        tick(); tick(); tick();
        chk(!data_oe && !rdy && data_o == 0, "R1", {data_oe, rdy}, 0);
        rst_n = 1'b1;
        tick();

        // R2 latch and R12 array contents
        cur_req = "R2";
        ce_n = 0; lat_n = 0; addr = 19'd5; oe_n = 0;
        bcyc(1);
        lat_n = 1;
        tick();
        chk(data_oe && data_o == ref_word(5), "R2/R12", data_o, ref_word(5));
        chk(rdy == 1'b1, "R10", rdy, 1);

        // R3 stepping
        cur_req = "R3";
        adv_n = 0;
        bcyc(3);
        adv_n = 1;
        tick();
        chk(data_o == ref_word(8), "R3", data_o, ref_word(8));

        // R5 hold
        cur_req = "R5";
        bcyc(2);
        chk(data_oe && data_o == ref_word(8), "R5", data_o, ref_word(8));

        // R6 suspend / resume
        cur_req = "R6";
        oe_n = 1;
        bcyc(2);
        chk(!data_oe && data_o == 0, "R6", data_o, 0);
        oe_n = 0;
        tick();
        chk(data_oe && data_o == ref_word(8), "R6", data_o, ref_word(8));

        // R4 stepping with bus released
        cur_req = "R4";
        od_n = 0; adv_n = 0;
        bcyc(2);
        chk(!data_oe, "R4", data_oe, 0);
        od_n = 1; adv_n = 1;
        tick();
        chk(data_o == ref_word(10), "R4", data_o, ref_word(10));
        oe_n = 1; adv_n = 0;
        bcyc(1);
        chk(!data_oe, "R4", data_oe, 0);
        oe_n = 0; adv_n = 1;
        tick();
        chk(data_o == ref_word(11), "R4", data_o, ref_word(11));

        // R3 wrap
        cur_req = "R3";
        lat_n = 0; addr = 19'h7FFFF;
        bcyc(1);
        lat_n = 1;
        tick();
        chk(data_o == ref_word(15), "R3", data_o, ref_word(15));
        adv_n = 0;
        bcyc(1);
        adv_n = 1;
        tick();
        chk(data_o == ref_word(0), "R3 wrap", data_o, ref_word(0));

        // R8 abort needs new latch
        cur_req = "R8";
        ce_n = 1;
        tick(); tick();
        chk(!data_oe && !rdy, "R8", {data_oe, rdy}, 0);
        ce_n = 0; adv_n = 0;
        bcyc(2);
        chk(!data_oe && !rdy, "R8", {data_oe, rdy}, 0);
        adv_n = 1;

        // R9 falling edge select (bclk is low here)
        cur_req = "R9";
        cfg_fall = 1; lat_n = 0; addr = 19'd3;
        half();   // rising, inactive
        chk(!data_oe, "R9", data_oe, 0);
        half();   // falling, active
        lat_n = 1;
        tick();
        chk(data_o == ref_word(3), "R9", data_o, ref_word(3));
        adv_n = 0;
        half();
        chk(data_o == ref_word(3), "R9", data_o, ref_word(3));
        half();
        chk(data_o == ref_word(4), "R9", data_o, ref_word(4));
        adv_n = 1;
        cfg_fall = 0;
        tick();

        // R10 ready lead
        cur_req = "R10";
        ce_n = 1;
        tick();
        ce_n = 0;
        tick();
        lat_n = 0; addr = 19'd7;
        tick();
        chk(rdy == 1'b0, "R10", rdy, 0);
        cfg_rdy_early = 1;
        tick();
        chk(rdy == 1'b1, "R10", rdy, 1);
        bcyc(1);
        lat_n = 1;
        tick();
        chk(rdy && data_o == ref_word(7), "R10", data_o, ref_word(7));
        cfg_rdy_early = 0;

        // R11 asynchronous mode
        cur_req = "R11";
        cfg_async = 1;
        tick();
        chk(!data_oe && !rdy, "R11", {data_oe, rdy}, 0);
        lat_n = 0; addr = 19'd2;
        bcyc(1);
        lat_n = 1; cfg_async = 0;
        tick();
        chk(!data_oe && !rdy, "R11", {data_oe, rdy}, 0);

        // R1 reset mid-burst, R7 drive condition
        cur_req = "R7";
        lat_n = 0; addr = 19'd9;
        bcyc(1);
        lat_n = 1;
        tick();
        chk(data_oe && data_o == ref_word(9), "R7", data_o, ref_word(9));
        cur_req = "R1";
        rst_n = 0;
        tick();
        chk(!data_oe && !rdy && data_o == 0, "R1", {data_oe, rdy}, 0);
        rst_n = 1;
        tick(); tick();
        chk(!data_oe, "R1/R8", data_oe, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule